// File: doc/BRIEF.md
# I/O Translation Unit Register Bank

This block is the software-visible register file of an I/O address translator. It sits on a simple word-wide read/write bus and holds the translator's control word, the page-table base, two flush registers, the asynchronous fault status and fault address, the bus arbiter enable, a configuration word per expansion slot, the slot arbitration enable and a chip mask identifier. Each register keeps only the bits its write mask lets through. Some registers also carry bits that are always 1, and one register merges new data into its old value instead of replacing it.

The bank also serves the translator. It decodes the 3-bit window-size field of the control word into the start address of the I/O window, and it passes on the enable bit and the page-table base. The translator reports a failed lookup on a capture port. The bank then fills the fault registers and raises a level interrupt. Software clears the interrupt by touching either fault register. Reads answer one cycle after the request.

Top module: `iommu_csr_bank`

## Requirements
- R1: After reset, a read returns: control = 0x05000000 (the implementation code 0x05 in bits [31:24]), fault status = 0x00800000, arbiter enable = 0x00000003, arbitration enable = 0x00000008, mask ID = 0x23000000. Every other register reads 0. The window start, the enable output and the interrupt are 0.
- R2: A full-word read raises `bus_rvalid` in the next cycle, with the value the register held when the request was taken. A read of an unmapped offset returns 0.
- R3: A control write (offset 0x0000) stores `wdata & 0x1D`, and bits [31:24] keep the implementation code. Bit 0 drives `xlt_enable`.
- R4: A control write loads the window start with 0xFFFFFFFF shifted left by 24 + bits [4:2]. Code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R5: The page-table base (0x0004) keeps `wdata & 0x07FFFC00`, and its value is driven on `xlt_pt_base`.
- R6: The whole-TLB flush word (0x0014) and the page flush word (0x0018) store all 32 bits.
- R7: Fault status (0x1000) stores `(wdata & 0xFF0FFFFF) | 0x00800000`. Fault address (0x1004) stores all 32 bits.
- R8: Arbiter enable (0x1008) stores `(wdata & 0x801F000F) | 1`. Slot configuration i (0x1010 + 4*i, i = 0..3) stores `wdata & 0x00010003`.
- R9: Arbitration enable (0x2000) stores `(wdata & 0x001F0000) | 0x8`. A mask ID write (0x3018) ORs `wdata & 0x00FFFFFF` into the current value.
- R10: A capture pulse sets fault status to 0xC0820000, or to 0xC0860000 when the failing access was a read. It sets the fault address to the page address with bits [11:0] cleared, and sets `irq` in the next cycle.
- R11: A full-word read or write of either fault register clears `irq` in the next cycle.
- R12: When a capture and a software access to the fault registers fall in the same cycle, the capture wins. The fault registers take the captured values, `irq` stays 1, and a read in that cycle returns the old contents.
- R13: An access that is not a full aligned word has no effect: it changes no register, does not clear `irq`, and a read answers 0. A write to an unmapped offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the bank |
| bus_be | input | 4 | Byte enables; all four needed for an access to count |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after the request |
| bus_rdata | output | DATA_W | Read response data |
| flt_capture | input | 1 | Translator reports a failed lookup |
| flt_page_addr | input | DATA_W | Address of the failed lookup |
| flt_is_read | input | 1 | Failed lookup was a read |
| xlt_enable | output | 1 | Translation enable |
| xlt_win_start | output | DATA_W | Start address of the I/O window |
| xlt_pt_base | output | DATA_W | Page-table base |
| irq | output | 1 | Level fault interrupt |

## Verification
A wrong mask or a missing forced bit shows up in the read that follows the write, one cycle after the request. A wrong enable, base or window start appears on the translator outputs right after the control or base write. A fault-state error shows on `irq` one cycle after the capture or the fault-register access. The cases where timing matters are a capture that meets a software access in the same cycle and a partial access while `irq` is high. In both, the interrupt and the read data of the following cycle tell the right ordering from the wrong one.

// File: rtl/iommu_csr_pkg.sv
package iommu_csr_pkg;

   localparam int unsigned REG_W = 32;

   // register byte offsets
   localparam int unsigned OFS_CTRL   = 'h0000;
   localparam int unsigned OFS_BASE   = 'h0004;
   localparam int unsigned OFS_TLBF   = 'h0014;
   localparam int unsigned OFS_PGF    = 'h0018;
   localparam int unsigned OFS_FSTAT  = 'h1000;
   localparam int unsigned OFS_FADDR  = 'h1004;
   localparam int unsigned OFS_ARB    = 'h1008;
   localparam int unsigned OFS_SLOT0  = 'h1010;
   localparam int unsigned OFS_SARB   = 'h2000;
   localparam int unsigned OFS_MASKID = 'h3018;

   // select vector slot indices; slot registers follow the fixed ones
   localparam int unsigned IX_CTRL   = 0;
   localparam int unsigned IX_BASE   = 1;
   localparam int unsigned IX_TLBF   = 2;
   localparam int unsigned IX_PGF    = 3;
   localparam int unsigned IX_FSTAT  = 4;
   localparam int unsigned IX_FADDR  = 5;
   localparam int unsigned IX_ARB    = 6;
   localparam int unsigned IX_SARB   = 7;
   localparam int unsigned IX_MASKID = 8;
   localparam int unsigned N_FIXED   = 9;

   // write masks and hard-wired bits
   localparam logic [REG_W-1:0] M_CTRL   = 32'h0000_001D;
   localparam logic [REG_W-1:0] M_BASE   = 32'h07FF_FC00;
   localparam logic [REG_W-1:0] M_FULL   = 32'hFFFF_FFFF;
   localparam logic [REG_W-1:0] M_FSTAT  = 32'hFF0F_FFFF;
   localparam logic [REG_W-1:0] M_ARB    = 32'h801F_000F;
   localparam logic [REG_W-1:0] M_SLOT   = 32'h0001_0003;
   localparam logic [REG_W-1:0] M_SARB   = 32'h001F_0000;
   localparam logic [REG_W-1:0] M_MASKID = 32'h00FF_FFFF;

   localparam logic [REG_W-1:0] F_FSTAT  = 32'h0080_0000;
   localparam logic [REG_W-1:0] F_ARB    = 32'h0000_0001;
   localparam logic [REG_W-1:0] F_SARB   = 32'h0000_0008;

   localparam logic [REG_W-1:0] R_ARB    = 32'h0000_0003;
   localparam logic [REG_W-1:0] R_MASKID = 32'h2300_0000;

   // fault status composition
   localparam logic [REG_W-1:0] FS_ERR   = 32'h8000_0000;
   localparam logic [REG_W-1:0] FS_LATE  = 32'h4000_0000;
   localparam logic [REG_W-1:0] FS_RD    = 32'h0004_0000;
   localparam logic [REG_W-1:0] FS_AVAL  = 32'h0002_0000;
   localparam logic [REG_W-1:0] FS_CAP   = FS_ERR | FS_LATE | F_FSTAT | FS_AVAL;
   localparam logic [REG_W-1:0] PAGE_MSK = 32'hFFFF_F000;

   localparam int unsigned WIN_MIN_LOG2 = 24;

   function automatic logic [REG_W-1:0] win_start_of(input logic [2:0] code);
      return {REG_W{1'b1}} << (WIN_MIN_LOG2 + int'(code));
   endfunction

endpackage

// File: rtl/iommu_csr_decode.sv
module iommu_csr_decode
   import iommu_csr_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int NUM_SLOTS = 4,
   localparam int NREG     = N_FIXED + NUM_SLOTS
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   hit
);

   always_comb begin
      hit = '0;
      hit[IX_CTRL]   = (addr == ADDR_W'(OFS_CTRL));
      hit[IX_BASE]   = (addr == ADDR_W'(OFS_BASE));
      hit[IX_TLBF]   = (addr == ADDR_W'(OFS_TLBF));
      hit[IX_PGF]    = (addr == ADDR_W'(OFS_PGF));
      hit[IX_FSTAT]  = (addr == ADDR_W'(OFS_FSTAT));
      hit[IX_FADDR]  = (addr == ADDR_W'(OFS_FADDR));
      hit[IX_ARB]    = (addr == ADDR_W'(OFS_ARB));
      hit[IX_SARB]   = (addr == ADDR_W'(OFS_SARB));
      hit[IX_MASKID] = (addr == ADDR_W'(OFS_MASKID));
      for (int s = 0; s < NUM_SLOTS; s++) begin
         hit[N_FIXED + s] = (addr == ADDR_W'(OFS_SLOT0 + 4 * s));
      end
   end

endmodule

// File: rtl/iommu_csr_field.sv
module iommu_csr_field #(
   parameter int           W     = 32,
   parameter logic [W-1:0] WMASK = '1,
   parameter logic [W-1:0] FORCE = '0,
   parameter logic [W-1:0] RSTV  = '0,
   parameter bit           ACCUM = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   if (ACCUM) begin : g_accum
      // new data merges into the held value
      always_ff @(posedge clk) begin
         if (!rst_n)  q <= RSTV;
         else if (we) q <= q | (wdata & WMASK);
      end
   end else begin : g_replace
      always_ff @(posedge clk) begin
         if (!rst_n)  q <= RSTV;
         else if (we) q <= (wdata & WMASK) | FORCE;
      end
   end

endmodule

// File: rtl/iommu_csr_fault.sv
module iommu_csr_fault
   import iommu_csr_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_stat,
   input  logic         wr_addr,
   input  logic         touch,
   input  logic [W-1:0] wdata,
   input  logic         cap,
   input  logic [W-1:0] cap_addr,
   input  logic         cap_read,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] addr_q,
   output logic         irq
);

   logic [W-1:0] cap_stat;

   always_comb begin
      cap_stat = W'(FS_CAP);
      if (cap_read) cap_stat = cap_stat | W'(FS_RD);
   end

   // a capture outranks every software effect in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= W'(F_FSTAT);
         addr_q <= '0;
         irq    <= 1'b0;
      end else if (cap) begin
         stat_q <= cap_stat;
         addr_q <= cap_addr & W'(PAGE_MSK);
         irq    <= 1'b1;
      end else begin
         if (wr_stat) stat_q <= (wdata & W'(M_FSTAT)) | W'(F_FSTAT);
         if (wr_addr) addr_q <= wdata;
         if (touch)   irq    <= 1'b0;
      end
   end

endmodule

// File: rtl/iommu_csr_window.sv
module iommu_csr_window
   import iommu_csr_pkg::*;
#(
   parameter int W         = 32,
   parameter bit USE_TABLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [2:0]   code,
   output logic [W-1:0] start
);

   logic [W-1:0] next_start;

   if (USE_TABLE) begin : g_table
      always_comb begin
         unique case (code)
            3'd0: next_start = W'(32'hFF00_0000);
            3'd1: next_start = W'(32'hFE00_0000);
            3'd2: next_start = W'(32'hFC00_0000);
            3'd3: next_start = W'(32'hF800_0000);
            3'd4: next_start = W'(32'hF000_0000);
            3'd5: next_start = W'(32'hE000_0000);
            3'd6: next_start = W'(32'hC000_0000);
            default: next_start = W'(32'h8000_0000);
         endcase
      end
   end else begin : g_shift
      always_comb next_start = W'(win_start_of(code));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    start <= '0;
      else if (load) start <= next_start;
   end

endmodule

// File: rtl/iommu_csr_bank.sv
module iommu_csr_bank
   import iommu_csr_pkg::*;
#(
   parameter int         ADDR_W    = 14,
   parameter int         DATA_W    = 32,
   parameter int         NUM_SLOTS = 4,
   parameter logic [7:0] IMPL_VER  = 8'h05,
   parameter bit         WIN_TABLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_rvalid,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              flt_capture,
   input  logic [DATA_W-1:0] flt_page_addr,
   input  logic              flt_is_read,
   output logic              xlt_enable,
   output logic [DATA_W-1:0] xlt_win_start,
   output logic [DATA_W-1:0] xlt_pt_base,
   output logic              irq
);

   localparam int NREG = N_FIXED + NUM_SLOTS;
   localparam logic [DATA_W-1:0] CTRL_RST = {IMPL_VER, {(DATA_W-8){1'b0}}};

   if (DATA_W != 32) begin : g_bad_width
      $error("iommu_csr_bank: DATA_W must be 32");
   end
   if (ADDR_W < 14) begin : g_bad_addr
      $error("iommu_csr_bank: ADDR_W must reach offset 0x3018");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_bad_slots
      $error("iommu_csr_bank: NUM_SLOTS must be 1..4");
   end

   logic full_word, acc, wr_en;
   logic [NREG-1:0] hit;
   logic [NREG-1:0] we;

   assign full_word = (&bus_be) && (bus_addr[1:0] == 2'b00);
   assign acc       = bus_valid && full_word;
   assign wr_en     = acc && bus_write;
   assign we        = hit & {NREG{wr_en}};

   iommu_csr_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
      .addr (bus_addr),
      .hit  (hit)
   );

   logic [DATA_W-1:0] ctrl_q, base_q, tlbf_q, pgf_q, fstat_q, faddr_q;
   logic [DATA_W-1:0] arb_q, sarb_q, maskid_q;
   logic [DATA_W-1:0] slot_q [NUM_SLOTS];

   iommu_csr_field #(.W(DATA_W), .WMASK(DATA_W'(M_CTRL)), .FORCE(CTRL_RST),
                     .RSTV(CTRL_RST)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(we[IX_CTRL]), .wdata(bus_wdata), .q(ctrl_q));

   iommu_csr_field #(.W(DATA_W), .WMASK(DATA_W'(M_BASE))) u_base (
      .clk(clk), .rst_n(rst_n), .we(we[IX_BASE]), .wdata(bus_wdata), .q(base_q));

   iommu_csr_field #(.W(DATA_W), .WMASK(DATA_W'(M_FULL))) u_tlbf (
      .clk(clk), .rst_n(rst_n), .we(we[IX_TLBF]), .wdata(bus_wdata), .q(tlbf_q));

   iommu_csr_field #(.W(DATA_W), .WMASK(DATA_W'(M_FULL))) u_pgf (
      .clk(clk), .rst_n(rst_n), .we(we[IX_PGF]), .wdata(bus_wdata), .q(pgf_q));

   iommu_csr_field #(.W(DATA_W), .WMASK(DATA_W'(M_ARB)), .FORCE(DATA_W'(F_ARB)),
                     .RSTV(DATA_W'(R_ARB))) u_arb (
      .clk(clk), .rst_n(rst_n), .we(we[IX_ARB]), .wdata(bus_wdata), .q(arb_q));

   iommu_csr_field #(.W(DATA_W), .WMASK(DATA_W'(M_SARB)), .FORCE(DATA_W'(F_SARB)),
                     .RSTV(DATA_W'(F_SARB))) u_sarb (
      .clk(clk), .rst_n(rst_n), .we(we[IX_SARB]), .wdata(bus_wdata), .q(sarb_q));

   iommu_csr_field #(.W(DATA_W), .WMASK(DATA_W'(M_MASKID)),
                     .RSTV(DATA_W'(R_MASKID)), .ACCUM(1'b1)) u_maskid (
      .clk(clk), .rst_n(rst_n), .we(we[IX_MASKID]), .wdata(bus_wdata), .q(maskid_q));

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      iommu_csr_field #(.W(DATA_W), .WMASK(DATA_W'(M_SLOT))) u_slot (
         .clk(clk), .rst_n(rst_n), .we(we[N_FIXED + s]), .wdata(bus_wdata),
         .q(slot_q[s]));
   end

   iommu_csr_fault #(.W(DATA_W)) u_fault (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stat  (we[IX_FSTAT]),
      .wr_addr  (we[IX_FADDR]),
      .touch    (acc && (hit[IX_FSTAT] || hit[IX_FADDR])),
      .wdata    (bus_wdata),
      .cap      (flt_capture),
      .cap_addr (flt_page_addr),
      .cap_read (flt_is_read),
      .stat_q   (fstat_q),
      .addr_q   (faddr_q),
      .irq      (irq)
   );

   iommu_csr_window #(.W(DATA_W), .USE_TABLE(WIN_TABLE)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (we[IX_CTRL]),
      .code  (bus_wdata[4:2]),
      .start (xlt_win_start)
   );

   // read path: OR of selected registers, zero when nothing matches
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (hit[IX_CTRL])   rd_mux = rd_mux | ctrl_q;
      if (hit[IX_BASE])   rd_mux = rd_mux | base_q;
      if (hit[IX_TLBF])   rd_mux = rd_mux | tlbf_q;
      if (hit[IX_PGF])    rd_mux = rd_mux | pgf_q;
      if (hit[IX_FSTAT])  rd_mux = rd_mux | fstat_q;
      if (hit[IX_FADDR])  rd_mux = rd_mux | faddr_q;
      if (hit[IX_ARB])    rd_mux = rd_mux | arb_q;
      if (hit[IX_SARB])   rd_mux = rd_mux | sarb_q;
      if (hit[IX_MASKID]) rd_mux = rd_mux | maskid_q;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (hit[N_FIXED + s]) rd_mux = rd_mux | slot_q[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_valid && !bus_write;
         bus_rdata  <= (bus_valid && !bus_write && full_word) ? rd_mux : '0;
      end
   end

   assign xlt_enable  = ctrl_q[0];
   assign xlt_pt_base = base_q;

endmodule

// File: rtl/iommu_csr_checker.sv
module iommu_csr_checker #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rvalid,
   input logic              flt_capture,
   input logic              xlt_enable,
   input logic [DATA_W-1:0] xlt_win_start,
   input logic [DATA_W-1:0] xlt_pt_base,
   input logic              irq
);

   logic whole, fault_hit, ctrl_wr;
   assign whole     = (&bus_be) && (bus_addr[1:0] == 2'b00);
   assign fault_hit = (bus_addr == ADDR_W'('h1000)) || (bus_addr == ADDR_W'('h1004));
   assign ctrl_wr   = bus_valid && bus_write && whole && (bus_addr == '0);

   assert_rvalid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> bus_rvalid);

   assert_rvalid_only_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> !bus_rvalid);

   assert_enable_follows_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (xlt_enable == $past(bus_wdata[0])));

   assert_window_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (xlt_win_start[DATA_W-1] && (xlt_win_start[23:0] == '0)));

   assert_base_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xlt_pt_base & ~DATA_W'(32'h07FF_FC00)) == '0);

   assert_capture_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flt_capture |=> irq);

   assert_irq_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(flt_capture));

   assert_touch_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && whole && fault_hit && !flt_capture) |=> !irq);

   assert_partial_inert_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && !whole) |=>
         ($stable(xlt_enable) && $stable(xlt_win_start) && $stable(xlt_pt_base)));

endmodule

bind iommu_csr_bank iommu_csr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_valid     (bus_valid),
   .bus_write     (bus_write),
   .bus_addr      (bus_addr),
   .bus_be        (bus_be),
   .bus_wdata     (bus_wdata),
   .bus_rvalid    (bus_rvalid),
   .flt_capture   (flt_capture),
   .xlt_enable    (xlt_enable),
   .xlt_win_start (xlt_win_start),
   .xlt_pt_base   (xlt_pt_base),
   .irq           (irq)
);

// File: tb/iommu_csr_bank_test.sv
module iommu_csr_bank_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] CTRL_RST = 32'h0500_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [13:0] bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [31:0] bus_rdata;
   logic        flt_capture = 1'b0;
   logic [31:0] flt_page_addr = '0;
   logic        flt_is_read = 1'b0;
   logic        xlt_enable;
   logic [31:0] xlt_win_start;
   logic [31:0] xlt_pt_base;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   iommu_csr_bank uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .flt_capture(flt_capture), .flt_page_addr(flt_page_addr),
      .flt_is_read(flt_is_read), .xlt_enable(xlt_enable),
      .xlt_win_start(xlt_win_start), .xlt_pt_base(xlt_pt_base), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a read response appears
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2: unexpected response actual %08h expected none", bus_rdata);
         end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   // driver: one access, optionally with a capture in the same cycle
   task automatic access(input bit wr, input logic [13:0] a, input logic [31:0] d,
                         input logic [3:0] be, input bit cap, input logic [31:0] ca,
                         input bit crd, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_valid     = 1'b1;
      bus_write     = wr;
      bus_addr      = a;
      bus_wdata     = d;
      bus_be        = be;
      flt_capture   = cap;
      flt_page_addr = ca;
      flt_is_read   = crd;
      if (!wr) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      @(negedge clk);
      bus_valid   = 1'b0;
      bus_write   = 1'b0;
      flt_capture = 1'b0;
      bus_be      = '0;
   endtask

   task automatic wr(input logic [13:0] a, input logic [31:0] d);
      access(1'b1, a, d, 4'hF, 1'b0, '0, 1'b0, '0, "");
   endtask

   task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
      access(1'b0, a, '0, 4'hF, 1'b0, '0, 1'b0, exp, tag);
   endtask

   task automatic capture(input logic [31:0] ca, input bit crd);
      @(negedge clk);
      flt_capture   = 1'b1;
      flt_page_addr = ca;
      flt_is_read   = crd;
      @(negedge clk);
      flt_capture = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 enable", {31'b0, xlt_enable}, 32'h0);
      check("R1 window", xlt_win_start, 32'h0);
      check("R1 base", xlt_pt_base, 32'h0);
      rd(14'h0000, CTRL_RST,      "R1 ctrl");
      rd(14'h0004, 32'h0,         "R1 base rd");
      rd(14'h0014, 32'h0,         "R1 tlbf");
      rd(14'h0018, 32'h0,         "R1 pgf");
      rd(14'h1000, 32'h0080_0000, "R1 fstat");
      rd(14'h1004, 32'h0,         "R1 faddr");
      rd(14'h1008, 32'h0000_0003, "R1 arb");
      rd(14'h2000, 32'h0000_0008, "R1 sarb");
      rd(14'h3018, 32'h2300_0000, "R1 maskid");
      for (int s = 0; s < 4; s++) rd(14'h1010 + 14'(4*s), 32'h0, "R1 slot");

      // R3 / R4 control and window decode
      for (int c = 0; c < 8; c++) begin
         logic [31:0] v;
         v = 32'hFFFF_FFE2 | (32'(c) << 2) | 32'(c & 1);
         wr(14'h0000, v);
         check("R4 window", xlt_win_start, 32'hFFFF_FFFF << (24 + c));
         check("R3 enable", {31'b0, xlt_enable}, 32'(c & 1));
         rd(14'h0000, CTRL_RST | (v & 32'h1D), "R3 ctrl");
      end

      // R5 base
      wr(14'h0004, 32'hFFFF_FFFF);
      check("R5 base out", xlt_pt_base, 32'h07FF_FC00);
      rd(14'h0004, 32'h07FF_FC00, "R5 base rd");

      // R6 flush words
      wr(14'h0014, 32'hA5A5_1234);
      wr(14'h0018, 32'h5A5A_FEDC);
      rd(14'h0014, 32'hA5A5_1234, "R6 tlbf");
      rd(14'h0018, 32'h5A5A_FEDC, "R6 pgf");

      // R7 fault registers by software
      wr(14'h1000, 32'h0);
      rd(14'h1000, 32'h0080_0000, "R7 fstat zero");
      wr(14'h1000, 32'hFFFF_FFFF);
      rd(14'h1000, 32'hFF8F_FFFF, "R7 fstat ones");
      wr(14'h1004, 32'h1234_5678);
      rd(14'h1004, 32'h1234_5678, "R7 faddr");

      // R8 arbiter enable and slots
      wr(14'h1008, 32'h0);
      rd(14'h1008, 32'h0000_0001, "R8 arb zero");
      wr(14'h1008, 32'hFFFF_FFFF);
      rd(14'h1008, 32'h801F_000F, "R8 arb ones");
      for (int s = 0; s < 4; s++) begin
         logic [31:0] v;
         v = 32'hFFFF_FFFF ^ (32'h1 << s) ^ (32'h1 << (16 + s));
         wr(14'h1010 + 14'(4*s), v);
         rd(14'h1010 + 14'(4*s), v & 32'h0001_0003, "R8 slot");
      end

      // R9 arbitration enable and accumulating mask ID
      wr(14'h2000, 32'h0);
      rd(14'h2000, 32'h0000_0008, "R9 sarb zero");
      wr(14'h2000, 32'hFFFF_FFFF);
      rd(14'h2000, 32'h001F_0008, "R9 sarb ones");
      wr(14'h3018, 32'h0000_00F0);
      rd(14'h3018, 32'h2300_00F0, "R9 maskid or1");
      wr(14'h3018, 32'h0000_000F);
      rd(14'h3018, 32'h2300_00FF, "R9 maskid or2");
      wr(14'h3018, 32'hFF00_0000);
      rd(14'h3018, 32'h2300_00FF, "R9 maskid masked");

      // R10 capture of a read fault, R13 partial read leaves irq, R11 read clears
      capture(32'h00AB_C123, 1'b1);
      check("R10 irq set", {31'b0, irq}, 32'h1);
      access(1'b0, 14'h1000, '0, 4'h1, 1'b0, '0, 1'b0, 32'h0, "R13 partial read");
      check("R13 irq kept", {31'b0, irq}, 32'h1);
      rd(14'h1004, 32'h00AB_C000, "R10 faddr");
      check("R11 irq clr rd", {31'b0, irq}, 32'h0);
      rd(14'h1000, 32'hC086_0000, "R10 fstat read");

      // R10 capture of a write fault, R11 write clears
      capture(32'hFFFF_F0FF, 1'b0);
      check("R10 irq set w", {31'b0, irq}, 32'h1);
      rd(14'h1000, 32'hC082_0000, "R10 fstat write");
      capture(32'h0000_1FFF, 1'b0);
      wr(14'h2000, 32'h0);
      check("R11 irq other", {31'b0, irq}, 32'h1);
      wr(14'h1004, 32'h0);
      check("R11 irq clr wr", {31'b0, irq}, 32'h0);

      // R12 capture beats same-cycle software write and read
      access(1'b1, 14'h1000, 32'h0, 4'hF, 1'b1, 32'h0077_7777, 1'b0, '0, "");
      check("R12 irq", {31'b0, irq}, 32'h1);
      access(1'b0, 14'h1004, '0, 4'hF, 1'b1, 32'h0088_8888, 1'b1, 32'h0077_7000,
             "R12 old faddr");
      check("R12 irq rd", {31'b0, irq}, 32'h1);
      rd(14'h1000, 32'hC086_0000, "R12 fstat");
      rd(14'h1004, 32'h0088_8000, "R12 faddr");
      check("R11 irq end", {31'b0, irq}, 32'h0);

      // R13 partial, misaligned and unmapped accesses
      access(1'b1, 14'h0000, 32'h0, 4'h3, 1'b0, '0, 1'b0, '0, "");
      check("R13 enable kept", {31'b0, xlt_enable}, 32'h1);
      check("R13 window kept", xlt_win_start, 32'h8000_0000);
      access(1'b1, 14'h0006, 32'h0, 4'hF, 1'b0, '0, 1'b0, '0, "");
      check("R13 base kept", xlt_pt_base, 32'h07FF_FC00);
      wr(14'h0100, 32'hDEAD_BEEF);
      rd(14'h0100, 32'h0, "R2 unmapped");
      rd(14'h0008, 32'h0, "R2 unmapped gap");
      rd(14'h0000, CTRL_RST | 32'h1D, "R13 ctrl kept");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) check("R2 missing responses", 32'(exp_q.size()), 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule